// File: doc/BRIEF.md
# Masked Alarm Latch Controller

This block collects alarm conditions for a monitoring device and turns them into one alert line for a host. Every cycle it builds a 16-bit raw alarm vector. Fourteen bits of that vector come straight from external alarm inputs. The top two bits are summaries: each one is the OR of a group of detailed fault flags, after that group has passed through its own byte-wide masks. A per-bit enable mask then selects which raw bits are captured into a sticky status register. The alert output is a registered OR of that status register.

Software reaches the block through a simple synchronous register port. It can read the raw and latched vectors. It can write the enable mask and the group masks. It clears latched bits by writing ones to the status register.

At reset the enable mask is loaded from a default-mask input, which stands for stored configuration. Software may overwrite the active mask at any later time, and doing so leaves the default input untouched.

Top module: `alarm_latch_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, the following hold: status is 0, `alert_o` is 0, every group mask is 0, and the enable register equals `dflt_mask_i`.
- R2: A status bit is set at a clock edge when its raw bit and its enable bit are both 1 in the cycle before that edge (per-bit AND).
- R3: A set status bit stays set after its raw bit returns to 0, until software clears it.
- R4: A write to address 1 (status) clears each status bit whose write-data bit is 1. Write-data bits that are 0 have no effect, and such a write never sets a bit.
- R5: If a clear and a qualifying raw assertion hit the same status bit in the same cycle, the bit ends up set.
- R6: `alert_o` equals the OR of all status bits as they were one cycle earlier. Raw bits that are not latched never drive it.
- R7: While the enable register is all zeros, no status bit is ever set.
- R8: Raw bit 15 is 1 when any safety flag is 1 and its mask bit is 1. The safety masks sit at addresses 3, 4 and 5 and cover flags [7:0], [15:8] and [23:16] respectively.
- R9: Raw bit 14 is formed the same way from the permanent-fail flags and the masks at addresses 6 to 9, which cover flags [7:0], [15:8], [23:16] and [31:24]. Raw bits [13:0] equal `ext_alarm_i`.
- R10: A read with `reg_rd_i` high returns its value on `reg_rdata_o` after the next clock edge; between reads the output holds. Address 0 returns raw, 1 returns status and 2 returns enable. Addresses 3 to 9 return the mask byte in bits [7:0] with zeros above it. Any other address returns 0.
- R11: A write to address 2 replaces the enable mask with the write data. A later reset reloads the enable mask from `dflt_mask_i`.
- R12: Writes to address 0, and writes to unmapped addresses, change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_alarm_i | input | 14 | External raw alarm conditions, raw bits [13:0] |
| safe_flags_i | input | 24 | Detailed safety flags |
| perm_flags_i | input | 32 | Detailed permanent-fail flags |
| dflt_mask_i | input | 16 | Default enable mask loaded at reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Registered read data |
| alert_o | output | 1 | Registered alert, OR of latched status |

## Verification
The assertions take for granted three things about the inputs. Reset is held at the first clock edge. `dflt_mask_i`, the alarm inputs and the register port are driven with known values from that edge on. At most one register access is presented per cycle, so write and read strobes never collide with an unknown address.

The stimulus changes every input only at the falling edge. It keeps every input at a known value from time zero. It draws addresses from the mapped range plus a few unmapped ones, which exercises the write-ignore paths without ever leaving an input undriven.

// File: rtl/alm_pkg.sv
package alm_pkg;

    localparam int RAW_W    = 16;
    localparam int EXT_W    = 14;
    localparam int SF_BYTES = 3;
    localparam int PF_BYTES = 4;
    localparam int SF_POS   = 15;
    localparam int PF_POS   = 14;
    localparam int ADDR_W   = 4;

    typedef logic [RAW_W-1:0]  alm_vec_t;
    typedef logic [ADDR_W-1:0] reg_addr_t;

    localparam reg_addr_t ADR_RAW     = reg_addr_t'(0);
    localparam reg_addr_t ADR_STAT    = reg_addr_t'(1);
    localparam reg_addr_t ADR_EN      = reg_addr_t'(2);
    localparam reg_addr_t ADR_SF_BASE = reg_addr_t'(3);
    localparam reg_addr_t ADR_PF_BASE = reg_addr_t'(3 + SF_BYTES);

    typedef struct packed {
        logic      wr;
        reg_addr_t addr;
        alm_vec_t  data;
    } reg_req_t;

    // Write hits a given address
    function automatic logic req_hits(reg_req_t q, reg_addr_t a);
        return q.wr && (q.addr == a);
    endfunction

    // Bits requested for write-one-to-clear
    function automatic alm_vec_t w1c_bits(reg_req_t q);
        return req_hits(q, ADR_STAT) ? q.data : '0;
    endfunction

endpackage

// File: rtl/alm_group_reduce.sv
module alm_group_reduce #(
    parameter int NBYTES = 3
) (
    input  logic [NBYTES*8-1:0]    flags_i,
    input  logic [NBYTES-1:0][7:0] mask_i,
    output logic                   hit_o
);
    logic [NBYTES-1:0] byte_hit;

    for (genvar g = 0; g < NBYTES; g++) begin : g_byte
        assign byte_hit[g] = |(flags_i[g*8 +: 8] & mask_i[g]);
    end

    assign hit_o = |byte_hit;
endmodule

// File: rtl/alm_cfg_regs.sv
module alm_cfg_regs
    import alm_pkg::*;
#(
    parameter int NSF = SF_BYTES,
    parameter int NPF = PF_BYTES
) (
    input  logic                clk,
    input  logic                rst,
    input  alm_vec_t            dflt_i,
    input  reg_req_t            req_i,
    output alm_vec_t            enable_o,
    output logic [NSF-1:0][7:0] sf_mask_o,
    output logic [NPF-1:0][7:0] pf_mask_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            enable_o <= dflt_i;
        end else if (req_hits(req_i, ADR_EN)) begin
            enable_o <= req_i.data;
        end
    end

    for (genvar g = 0; g < NSF; g++) begin : g_sf
        always_ff @(posedge clk) begin
            if (rst) begin
                sf_mask_o[g] <= '0;
            end else if (req_hits(req_i, reg_addr_t'(ADR_SF_BASE + g))) begin
                sf_mask_o[g] <= req_i.data[7:0];
            end
        end
    end

    for (genvar g = 0; g < NPF; g++) begin : g_pf
        always_ff @(posedge clk) begin
            if (rst) begin
                pf_mask_o[g] <= '0;
            end else if (req_hits(req_i, reg_addr_t'(ADR_PF_BASE + g))) begin
                pf_mask_o[g] <= req_i.data[7:0];
            end
        end
    end
endmodule

// File: rtl/alm_status_latch.sv
module alm_status_latch
    import alm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  alm_vec_t raw_i,
    input  alm_vec_t enable_i,
    input  alm_vec_t clr_i,
    output alm_vec_t status_o,
    output logic     alert_o
);
    alm_vec_t set_bits;
    alm_vec_t status_d;

    always_comb begin
        set_bits = raw_i & enable_i;
        // Set dominates clear so a coincident event is kept
        status_d = (status_o & ~clr_i) | set_bits;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_o <= '0;
            alert_o  <= 1'b0;
        end else begin
            status_o <= status_d;
            alert_o  <= |status_o;
        end
    end
endmodule

// File: rtl/alm_read_port.sv
module alm_read_port
    import alm_pkg::*;
#(
    parameter int NSF = SF_BYTES,
    parameter int NPF = PF_BYTES
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rd_i,
    input  reg_addr_t           addr_i,
    input  alm_vec_t            raw_i,
    input  alm_vec_t            status_i,
    input  alm_vec_t            enable_i,
    input  logic [NSF-1:0][7:0] sf_mask_i,
    input  logic [NPF-1:0][7:0] pf_mask_i,
    output alm_vec_t            rdata_o
);
    alm_vec_t sel;

    always_comb begin
        sel = '0;
        if (addr_i == ADR_RAW)  sel = raw_i;
        if (addr_i == ADR_STAT) sel = status_i;
        if (addr_i == ADR_EN)   sel = enable_i;
        for (int i = 0; i < NSF; i++) begin
            if (addr_i == reg_addr_t'(ADR_SF_BASE + i)) sel = {8'h00, sf_mask_i[i]};
        end
        for (int i = 0; i < NPF; i++) begin
            if (addr_i == reg_addr_t'(ADR_PF_BASE + i)) sel = {8'h00, pf_mask_i[i]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_o <= '0;
        end else if (rd_i) begin
            rdata_o <= sel;
        end
    end
endmodule

// File: rtl/alarm_latch_ctrl.sv
module alarm_latch_ctrl
    import alm_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [EXT_W-1:0]      ext_alarm_i,
    input  logic [SF_BYTES*8-1:0] safe_flags_i,
    input  logic [PF_BYTES*8-1:0] perm_flags_i,
    input  logic [RAW_W-1:0]      dflt_mask_i,
    input  logic                  reg_wr_i,
    input  logic                  reg_rd_i,
    input  logic [ADDR_W-1:0]     reg_addr_i,
    input  logic [RAW_W-1:0]      reg_wdata_i,
    output logic [RAW_W-1:0]      reg_rdata_o,
    output logic                  alert_o
);
    reg_req_t                   req;
    alm_vec_t                   raw_vec;
    alm_vec_t                   status_q;
    alm_vec_t                   enable_q;
    alm_vec_t                   clr_vec;
    logic [SF_BYTES-1:0][7:0]   sf_mask;
    logic [PF_BYTES-1:0][7:0]   pf_mask;
    logic                       sf_hit;
    logic                       pf_hit;

    assign req     = '{wr: reg_wr_i, addr: reg_addr_i, data: reg_wdata_i};
    assign clr_vec = w1c_bits(req);

    alm_group_reduce #(.NBYTES(SF_BYTES)) u_sf_red (
        .flags_i (safe_flags_i),
        .mask_i  (sf_mask),
        .hit_o   (sf_hit)
    );

    alm_group_reduce #(.NBYTES(PF_BYTES)) u_pf_red (
        .flags_i (perm_flags_i),
        .mask_i  (pf_mask),
        .hit_o   (pf_hit)
    );

    always_comb begin
        raw_vec              = '0;
        raw_vec[EXT_W-1:0]   = ext_alarm_i;
        raw_vec[SF_POS]      = sf_hit;
        raw_vec[PF_POS]      = pf_hit;
    end

    alm_cfg_regs #(.NSF(SF_BYTES), .NPF(PF_BYTES)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .dflt_i    (dflt_mask_i),
        .req_i     (req),
        .enable_o  (enable_q),
        .sf_mask_o (sf_mask),
        .pf_mask_o (pf_mask)
    );

    alm_status_latch u_stat (
        .clk      (clk),
        .rst      (rst),
        .raw_i    (raw_vec),
        .enable_i (enable_q),
        .clr_i    (clr_vec),
        .status_o (status_q),
        .alert_o  (alert_o)
    );

    alm_read_port #(.NSF(SF_BYTES), .NPF(PF_BYTES)) u_rd (
        .clk       (clk),
        .rst       (rst),
        .rd_i      (reg_rd_i),
        .addr_i    (reg_addr_i),
        .raw_i     (raw_vec),
        .status_i  (status_q),
        .enable_i  (enable_q),
        .sf_mask_i (sf_mask),
        .pf_mask_i (pf_mask),
        .rdata_o   (reg_rdata_o)
    );
endmodule

// File: rtl/alm_latch_chk.sv
module alm_latch_chk
    import alm_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input alm_vec_t  raw,
    input alm_vec_t  status,
    input alm_vec_t  enable,
    input alm_vec_t  dflt,
    input logic      alert,
    input logic      wr,
    input reg_addr_t addr,
    input alm_vec_t  wdata
);
    alm_vec_t qual;
    alm_vec_t keep;

    assign qual = raw & enable;
    assign keep = status & ~((wr && addr == ADR_STAT) ? wdata : '0);

    // R1: reset state
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (status == '0 && !alert && enable == $past(dflt)));

    // R2 and R5: qualifying raw bits are latched, even against a clear
    p_latch_and_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status & $past(qual)) == $past(qual)));

    // R3: set bits not cleared stay set
    p_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status & $past(keep)) == $past(keep)));

    // R4: a bit can only become set through a qualifying raw bit
    p_no_spurious_set_r4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status & ~$past(status) & ~$past(qual)) == '0));

    // R6: alert follows the OR of status one cycle later
    p_alert_or_r6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (alert == (|$past(status))));

    // R7: zero enable and empty status stay empty
    p_zero_enable_r7: assert property (@(posedge clk) disable iff (rst)
        (enable == '0 && status == '0) |=> (status == '0));
endmodule

bind alarm_latch_ctrl alm_latch_chk chk_i (
    .clk    (clk),
    .rst    (rst),
    .raw    (raw_vec),
    .status (status_q),
    .enable (enable_q),
    .dflt   (dflt_mask_i),
    .alert  (alert_o),
    .wr     (reg_wr_i),
    .addr   (reg_addr_i),
    .wdata  (reg_wdata_i)
);

// File: tb/alarm_latch_ctrl_tb_top.sv
`timescale 1ns/1ps
module alarm_latch_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [13:0] ext = '0;
    logic [23:0] sf = '0;
    logic [31:0] pf = '0;
    logic [15:0] dflt = 16'h00F0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [3:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        alert;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference model state
    logic [15:0]      m_en, m_stat;
    logic [2:0][7:0]  m_sfm;
    logic [3:0][7:0]  m_pfm;
    logic             m_alert;
    logic [15:0]      m_rdata;

    always #2 clk = ~clk;

    alarm_latch_ctrl dut_i (
        .clk (clk), .rst (rst), .ext_alarm_i (ext), .safe_flags_i (sf),
        .perm_flags_i (pf), .dflt_mask_i (dflt), .reg_wr_i (wr), .reg_rd_i (rd),
        .reg_addr_i (addr), .reg_wdata_i (wdata), .reg_rdata_o (rdata), .alert_o (alert)
    );

    function automatic logic [15:0] f_raw();
        logic [15:0] r;
        r = {2'b00, ext};
        r[15] = |(sf & {m_sfm[2], m_sfm[1], m_sfm[0]});
        r[14] = |(pf & {m_pfm[3], m_pfm[2], m_pfm[1], m_pfm[0]});
        return r;
    endfunction

    function automatic logic [15:0] f_read(logic [3:0] a);
        case (a)
            4'd0: return f_raw();
            4'd1: return m_stat;
            4'd2: return m_en;
            4'd3, 4'd4, 4'd5: return {8'h00, m_sfm[a-3]};
            4'd6, 4'd7, 4'd8, 4'd9: return {8'h00, m_pfm[a-6]};
            default: return 16'h0000;
        endcase
    endfunction

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_en = dflt; m_stat = '0; m_sfm = '0; m_pfm = '0;
        m_alert = 1'b0; m_rdata = '0;
    endtask

    task automatic do_reset(int n);
        rst = 1'b1; wr = 1'b0; rd = 1'b0;
        repeat (n) @(posedge clk);
        @(negedge clk);
        model_reset();
        check("R1 alert", {15'd0, alert}, 16'd0);
        check("R1 rdata", rdata, 16'd0);
        rst = 1'b0;
    endtask

    // one cycle: drive at negedge, update model, check at next negedge
    task automatic cyc(logic [13:0] e, logic [23:0] s, logic [31:0] p,
                       logic w, logic r, logic [3:0] a, logic [15:0] d, string tag);
        logic [15:0] raw, clr, nstat, nrd;
        logic        nalert;
        ext = e; sf = s; pf = p; wr = w; rd = r; addr = a; wdata = d;
        raw    = f_raw();
        clr    = (w && a == 4'd1) ? d : 16'h0000;
        nstat  = (m_stat & ~clr) | (raw & m_en);
        nalert = |m_stat;
        nrd    = r ? f_read(a) : m_rdata;
        @(posedge clk);
        m_stat = nstat; m_alert = nalert; m_rdata = nrd;
        if (w) begin
            if (a == 4'd2) m_en = d;
            if (a >= 4'd3 && a <= 4'd5) m_sfm[a-3] = d[7:0];
            if (a >= 4'd6 && a <= 4'd9) m_pfm[a-6] = d[7:0];
        end
        @(negedge clk);
        check("R6 alert", {15'd0, alert}, {15'd0, m_alert});
        if (r) check(tag, rdata, m_rdata);
    endtask

    task automatic rd_reg(logic [3:0] a, string tag);
        cyc(ext, sf, pf, 1'b0, 1'b1, a, 16'h0, tag);
    endtask

    task automatic wr_reg(logic [3:0] a, logic [15:0] d);
        cyc(ext, sf, pf, 1'b1, 1'b0, a, d, "wr");
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset(3);
        // R1: enable from default, status empty
        rd_reg(4'd2, "R1 enable");
        check("R1 enable value", rdata, 16'h00F0);
        rd_reg(4'd1, "R1 status");
        rd_reg(4'd4, "R1 mask");

        // R2: bits 0 and 4 raised, only bit 4 enabled
        cyc(14'h0011, '0, '0, 1'b0, 1'b0, 4'd0, 16'h0, "R2");
        ext = '0;
        rd_reg(4'd1, "R2 status");
        check("R2 latched bit", rdata, 16'h0010);
        // R3: raw gone, bit still set
        rd_reg(4'd1, "R3 sticky");
        check("R3 value", rdata, 16'h0010);
        // R4: writing to a clear bit and zeros has no effect
        wr_reg(4'd1, 16'h0001);
        rd_reg(4'd1, "R4 zero effect");
        check("R4 value", rdata, 16'h0010);
        wr_reg(4'd1, 16'h0010);
        rd_reg(4'd1, "R4 cleared");
        check("R4 clear value", rdata, 16'h0000);
        // R5: set and clear together
        cyc(14'h0010, '0, '0, 1'b1, 1'b0, 4'd1, 16'h0010, "R5");
        ext = '0;
        rd_reg(4'd1, "R5 set wins");
        check("R5 value", rdata, 16'h0010);
        wr_reg(4'd1, 16'hFFFF);
        // R7: zero enable, everything raised
        wr_reg(4'd2, 16'h0000);
        for (int i = 0; i < 4; i++) cyc(14'h3FFF, '1, '1, 1'b0, 1'b0, 4'd0, 16'h0, "R7");
        rd_reg(4'd1, "R7 nothing latched");
        check("R7 value", rdata, 16'h0000);
        ext = '0; sf = '0; pf = '0;
        // R8: safety mask B bit 2 -> flag 10
        wr_reg(4'd4, 16'hFF04);
        wr_reg(4'd2, 16'h8000);
        cyc('0, 24'h000404, '0, 1'b0, 1'b1, 4'd0, 16'h0, "R8 raw");
        check("R8 summary", rdata, 16'h8000);
        cyc('0, 24'h000004, '0, 1'b0, 1'b1, 4'd0, 16'h0, "R8 masked off");
        sf = '0;
        rd_reg(4'd1, "R8 status");
        rd_reg(4'd4, "R8 mask byte");
        check("R8 mask readback", rdata, 16'h0004);
        // R9: permanent-fail mask D bit 7 -> flag 31
        wr_reg(4'd9, 16'h0080);
        cyc(14'h0005, '0, 32'h8000_0000, 1'b0, 1'b1, 4'd0, 16'h0, "R9 raw");
        check("R9 summary", rdata, 16'h4005);
        pf = '0; ext = '0;
        // R10: unmapped read and hold between reads
        rd_reg(4'd15, "R10 unmapped");
        cyc('0, '0, '0, 1'b0, 1'b0, 4'd0, 16'h0, "R10");
        check("R10 hold", rdata, 16'h0000);
        // R12: writes to raw and unmapped change nothing
        wr_reg(4'd0, 16'hFFFF);
        wr_reg(4'd12, 16'hFFFF);
        rd_reg(4'd1, "R12 status");
        rd_reg(4'd2, "R12 enable");
        rd_reg(4'd0, "R12 raw");
        // R11: runtime overwrite then reset reload
        wr_reg(4'd2, 16'h1234);
        rd_reg(4'd2, "R11 write");
        check("R11 written", rdata, 16'h1234);
        do_reset(2);
        rd_reg(4'd2, "R11 reload");
        check("R11 default", rdata, 16'h00F0);

        // constrained random mix
        void'($urandom(32'd1234));
        for (int n = 0; n < 4000; n++) begin
            logic [13:0] e;
            logic [23:0] s;
            logic [31:0] p;
            logic        w, r;
            logic [3:0]  a;
            logic [15:0] d;
            e = 14'($urandom) & 14'($urandom) & 14'($urandom);
            s = 24'($urandom) & 24'($urandom) & 24'($urandom);
            p = 32'($urandom) & 32'($urandom) & 32'($urandom);
            w = ($urandom % 4) == 0;
            r = ($urandom % 2) == 0;
            a = 4'($urandom % 12);
            d = 16'($urandom);
            if (w && a == 4'd2) d = d | 16'($urandom);
            cyc(e, s, p, w, r, a, d, "R10 random read");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule